// File: doc/BRIEF.md
# Push-Button Stereo Volume Controller

This block is the digital control unit of a two-channel stepped attenuator. It turns three active-low push buttons (louder, quieter, mute) and an active-low standby level into a single tap code shared by both channels. Codes 0 to 31 are attenuation steps, with 0 the loudest. Code 32 is a dedicated mute setting. Codes 0 to 26 are 2 dB apart and 26 to 31 are 4 dB apart, so code 31 sits at -72 dB and code 32 at -90 dB.

Each time the code changes, or has to be re-applied, the block raises a one-cycle strobe. A downstream zero-crossing gate uses that strobe to latch the new code. All timing comes from a one-cycle millisecond tick supplied by the system. Every duration below is counted in ticks.

Button handling works as follows. Each button is filtered against contact bounce. Holding louder or quieter repeats the step, first slowly and then faster. The mute button toggles between code 32 and a remembered position. Each command is followed by a quiet window. If two buttons are down together, everything is cancelled until all buttons are up again. The standby input parks the wipers and keeps the position for the wake-up.

Top module: `pb_volume_ctrl`

## Requirements
- R1: A button counts as pressed only after its synchronised input has been low for 20 consecutive ticks, and as released after 8 consecutive high ticks. A low pulse of 10 ms produces no command.
- R2: A louder press lowers the code by one and a quieter press raises it by one. Each change comes with exactly one strobe, in the cycle the new code appears.
- R3: The code never wraps. A louder command at code 0 and a quieter command at code 31 leave the code unchanged and raise no strobe.
- R4: A louder or quieter button held down repeats its step on a fixed schedule. The first repeat comes 1000 ticks after the press command. Further repeats follow every 250 ticks up to 5000 ticks after the press, and every 125 ticks after that, until release.
- R5: A mute press while unmuted saves the code and jumps in one step to code 32. The next mute press restores the saved code.
- R6: For 40 ticks after any command, a new button press is ignored and stays ignored until that button is released.
- R7: While the code is 32, louder and quieter presses are ignored.
- R8: When two or more buttons are seen pressed at once, no command is issued, including repeats, until all buttons are released.
- R9: While standby is low, `parked` is high and presses are ignored. When standby returns high, `parked` falls together with one strobe carrying the unchanged code.
- R10: Reset leaves code 10 (-20 dB), no strobe and `parked` low.
- R11: The code stays within 0 to 32 and changes only in a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| up_n | input | 1 | Louder button, active low |
| dn_n | input | 1 | Quieter button, active low |
| mute_n | input | 1 | Mute toggle button, active low |
| stby_n | input | 1 | Standby request, active low |
| tap_code | output | 6 | Attenuation code, 0 loudest, 31 -72 dB, 32 mute |
| cmd_stb | output | 1 | One-cycle strobe announcing a code to apply |
| parked | output | 1 | Wipers disconnected for standby |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Re-press inside the quiet window.** A design that restarted commands on the release filter alone would take a second step.
- **Mute toggle round trip.** A design with a broken mute toggle would come back to the wrong code or step out of code 32 on a louder press.
- **Second button mid-hold.** A design that checked only for simultaneous first presses would keep auto-repeating after a second button joins.
- **Full hold from code 0 to code 31.** The bench measures the gaps between strobes. A wrong switch-over point between the slow and fast rates shows up as a 250 or 125 tick gap in the wrong place.
- **Overruns at both ends.** Holding past each end catches any wrap.
- **Standby wake-up.** The bench checks that exactly one restore strobe is issued and that the held code is unchanged.

// File: rtl/pbv_pkg.sv
package pbv_pkg;

  localparam int unsigned PBV_TAP_W = 6;
  localparam logic [PBV_TAP_W-1:0] PBV_MUTE_CODE = 6'd32;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_UP   = 2'd1,
    KIND_DN   = 2'd2,
    KIND_MUTE = 2'd3
  } pbv_kind_e;

  // one step toward 0 dB, saturating at code 0
  function automatic logic [PBV_TAP_W-1:0] louder(input logic [PBV_TAP_W-1:0] pos);
    return (pos == '0) ? pos : pos - 1'b1;
  endfunction

  // one step toward more attenuation, saturating at floor
  function automatic logic [PBV_TAP_W-1:0] quieter(input logic [PBV_TAP_W-1:0] pos,
                                                  input logic [PBV_TAP_W-1:0] floor);
    return (pos >= floor) ? pos : pos + 1'b1;
  endfunction

  // repeat cadence: first step at hold_ms, slow until hold_ms+span_ms, fast afterwards
  function automatic logic repeat_due(input int unsigned held_ms, input int unsigned since_ms,
                                      input int unsigned hold_ms, input int unsigned span_ms,
                                      input int unsigned slow_ms, input int unsigned fast_ms);
    if (held_ms == hold_ms) return 1'b1;
    if (held_ms < hold_ms) return 1'b0;
    if (held_ms <= hold_ms + span_ms) return since_ms == slow_ms;
    return since_ms == fast_ms;
  endfunction

  // one-hot button vector to command kind (bit0 louder, bit1 quieter, bit2 mute)
  function automatic pbv_kind_e kind_of(input logic [2:0] sel);
    case (sel)
      3'b001:  return KIND_UP;
      3'b010:  return KIND_DN;
      3'b100:  return KIND_MUTE;
      default: return KIND_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pbv_debounce.sv
module pbv_debounce #(
  parameter int unsigned PRESS_MS   = 20,
  parameter int unsigned RELEASE_MS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic raw_n,
  output logic pressed
);
  localparam int unsigned LIM_MAX = (PRESS_MS > RELEASE_MS) ? PRESS_MS : RELEASE_MS;
  localparam int unsigned CW      = $clog2(LIM_MAX + 1);

  logic [1:0]    sync_q;
  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic          live;
  logic [CW-1:0] limit;

  assign live    = ~sync_q[1];
  assign limit   = state_q ? CW'(RELEASE_MS) : CW'(PRESS_MS);
  assign pressed = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_n};
      if (live == state_q) begin
        cnt_q <= '0;
      end else if (ms_tick) begin
        if (cnt_q + 1'b1 >= limit) begin
          state_q <= live;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pbv_arbiter.sv
module pbv_arbiter import pbv_pkg::*; #(
  parameter int unsigned LOCK_MS      = 40,
  parameter int unsigned HOLD_MS      = 1000,
  parameter int unsigned SLOW_SPAN_MS = 4000,
  parameter int unsigned SLOW_MS      = 250,
  parameter int unsigned FAST_MS      = 125
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ms_tick,
  input  logic [2:0] pressed,
  input  logic      parked,
  output logic      cmd_fire,
  output pbv_kind_e cmd_kind,
  output logic      lock_busy,
  output logic      clash
);
  localparam int unsigned H_CAP = HOLD_MS + SLOW_SPAN_MS + 1;
  localparam int unsigned HW    = $clog2(H_CAP + 1);
  localparam int unsigned PMAX  = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
  localparam int unsigned PW    = $clog2(PMAX + 1);
  localparam int unsigned LW    = $clog2(LOCK_MS + 1);

  typedef enum logic [1:0] {ARB_IDLE, ARB_HOLD, ARB_SHUN} arb_st_e;

  arb_st_e       st_q, st_d;
  logic [2:0]    held_q, held_d, fire_sel;
  logic [HW-1:0] h_q, h_d, h_nx;
  logic [PW-1:0] p_q, p_d, p_nx;
  logic [LW-1:0] lock_q;
  logic          n_multi, n_single, due;

  assign n_multi   = $countones(pressed) > 1;
  assign n_single  = $countones(pressed) == 1;
  assign lock_busy = lock_q != '0;
  assign h_nx      = (h_q == HW'(H_CAP)) ? h_q : h_q + 1'b1;
  assign p_nx      = p_q + 1'b1;
  assign clash     = ((st_q == ARB_IDLE) && n_multi) ||
                     ((st_q == ARB_HOLD) && |(pressed & ~held_q));
  assign due       = repeat_due(32'(h_nx), 32'(p_nx), HOLD_MS, SLOW_SPAN_MS, SLOW_MS, FAST_MS);
  assign cmd_kind  = kind_of(fire_sel);

  always_comb begin
    st_d     = st_q;
    held_d   = held_q;
    h_d      = h_q;
    p_d      = p_q;
    cmd_fire = 1'b0;
    fire_sel = 3'b000;
    case (st_q)
      ARB_IDLE: begin
        if (clash) begin
          st_d = ARB_SHUN;
        end else if (n_single) begin
          if (lock_busy || parked) begin
            st_d = ARB_SHUN;
          end else begin
            cmd_fire = 1'b1;
            fire_sel = pressed;
            st_d     = ARB_HOLD;
            held_d   = pressed;
            h_d      = '0;
            p_d      = '0;
          end
        end
      end
      ARB_HOLD: begin
        if (clash || parked) begin
          st_d = ARB_SHUN;
        end else if (!(|(pressed & held_q))) begin
          st_d = ARB_IDLE;
        end else if (ms_tick) begin
          h_d = h_nx;
          if (32'(h_nx) > HOLD_MS) p_d = p_nx;
          if (!held_q[2] && due) begin
            p_d = '0;
            if (!lock_busy) begin
              cmd_fire = 1'b1;
              fire_sel = held_q;
            end
          end
        end
      end
      default: begin
        if (pressed == 3'b000) st_d = ARB_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ARB_IDLE;
      held_q <= 3'b000;
      h_q    <= '0;
      p_q    <= '0;
      lock_q <= '0;
    end else begin
      st_q   <= st_d;
      held_q <= held_d;
      h_q    <= h_d;
      p_q    <= p_d;
      if (cmd_fire)                 lock_q <= LW'(LOCK_MS);
      else if (ms_tick && lock_busy) lock_q <= lock_q - 1'b1;
    end
  end
endmodule

// File: rtl/pbv_position.sv
module pbv_position import pbv_pkg::*; #(
  parameter logic [PBV_TAP_W-1:0] RESET_TAP = 6'd10,
  parameter logic [PBV_TAP_W-1:0] FLOOR_TAP = 6'd31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stby_n,
  input  logic                 cmd_fire,
  input  pbv_kind_e            cmd_kind,
  output logic [PBV_TAP_W-1:0] tap_code,
  output logic                 cmd_stb,
  output logic                 parked,
  output logic                 wake_evt
);
  logic [1:0]           stby_q;
  logic                 parked_q, stb_q, stb_d;
  logic [PBV_TAP_W-1:0] pos_q, pos_d, saved_q, saved_d;
  logic                 muted;

  assign muted    = pos_q == PBV_MUTE_CODE;
  assign wake_evt = parked_q && stby_q[1];
  assign tap_code = pos_q;
  assign cmd_stb  = stb_q;
  assign parked   = parked_q;

  always_comb begin
    pos_d   = pos_q;
    saved_d = saved_q;
    stb_d   = 1'b0;
    if (wake_evt) begin
      stb_d = 1'b1;
    end else if (cmd_fire) begin
      case (cmd_kind)
        KIND_UP: if (!muted && pos_q != '0) begin
          pos_d = louder(pos_q);
          stb_d = 1'b1;
        end
        KIND_DN: if (!muted && pos_q < FLOOR_TAP) begin
          pos_d = quieter(pos_q, FLOOR_TAP);
          stb_d = 1'b1;
        end
        KIND_MUTE: begin
          if (muted) begin
            pos_d = saved_q;
          end else begin
            saved_d = pos_q;
            pos_d   = PBV_MUTE_CODE;
          end
          stb_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q   <= 2'b11;
      parked_q <= 1'b0;
      pos_q    <= RESET_TAP;
      saved_q  <= RESET_TAP;
      stb_q    <= 1'b0;
    end else begin
      stby_q   <= {stby_q[0], stby_n};
      parked_q <= ~stby_q[1];
      pos_q    <= pos_d;
      saved_q  <= saved_d;
      stb_q    <= stb_d;
    end
  end
endmodule

// File: rtl/pb_volume_ctrl.sv
module pb_volume_ctrl import pbv_pkg::*; #(
  parameter int unsigned PRESS_MS     = 20,
  parameter int unsigned RELEASE_MS   = 8,
  parameter int unsigned LOCK_MS      = 40,
  parameter int unsigned HOLD_MS      = 1000,
  parameter int unsigned SLOW_SPAN_MS = 4000,
  parameter int unsigned SLOW_MS      = 250,
  parameter int unsigned FAST_MS      = 125,
  parameter logic [5:0]  RESET_TAP    = 6'd10,
  parameter logic [5:0]  FLOOR_TAP    = 6'd31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       up_n,
  input  logic       dn_n,
  input  logic       mute_n,
  input  logic       stby_n,
  output logic [5:0] tap_code,
  output logic       cmd_stb,
  output logic       parked
);
  localparam int unsigned N_BTN = 3;

  logic [N_BTN-1:0] btn_raw_n;
  logic [N_BTN-1:0] btn_pressed;
  logic             cmd_fire;
  pbv_kind_e        cmd_kind;
  logic             lock_busy;
  logic             clash;
  logic             wake_evt;

  assign btn_raw_n = {mute_n, dn_n, up_n};

  for (genvar b = 0; b < N_BTN; b++) begin : g_btn
    pbv_debounce #(.PRESS_MS(PRESS_MS), .RELEASE_MS(RELEASE_MS)) u_deb (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .raw_n(btn_raw_n[b]), .pressed(btn_pressed[b])
    );
  end

  pbv_arbiter #(
    .LOCK_MS(LOCK_MS), .HOLD_MS(HOLD_MS), .SLOW_SPAN_MS(SLOW_SPAN_MS),
    .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pressed(btn_pressed),
    .parked(parked), .cmd_fire(cmd_fire), .cmd_kind(cmd_kind),
    .lock_busy(lock_busy), .clash(clash)
  );

  pbv_position #(.RESET_TAP(RESET_TAP), .FLOOR_TAP(FLOOR_TAP)) u_pos (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .cmd_fire(cmd_fire),
    .cmd_kind(cmd_kind), .tap_code(tap_code), .cmd_stb(cmd_stb),
    .parked(parked), .wake_evt(wake_evt)
  );
endmodule

// File: rtl/pbv_checker.sv
module pbv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pressed,
  input logic       cmd_fire,
  input logic       lock_busy,
  input logic       clash,
  input logic       parked,
  input logic [5:0] tap_code,
  input logic       cmd_stb
);
  // R11
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_code <= 6'd32);

  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |-> $stable(tap_code));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && tap_code != 6'd32 && $past(tap_code) != 6'd32 && tap_code != $past(tap_code))
    |-> (tap_code == $past(tap_code) + 6'd1 || $past(tap_code) == tap_code + 6'd1));

  // R5
  mute_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && tap_code == 6'd32 && !$past(parked)) |-> $past(tap_code) != 6'd32);

  // R6
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |-> !cmd_fire);

  // R8
  multi_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pressed) > 1 || clash) |-> !cmd_fire);

  // R9
  parked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> !cmd_fire);

  // R9
  wake_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parked) |-> cmd_stb);
endmodule

bind pb_volume_ctrl pbv_checker chk_i (
  .clk(clk), .rst_n(rst_n), .pressed(btn_pressed), .cmd_fire(cmd_fire),
  .lock_busy(lock_busy), .clash(clash), .parked(parked),
  .tap_code(tap_code), .cmd_stb(cmd_stb)
);

// File: tb/pb_volume_ctrl_test.sv
module pb_volume_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick = 1'b0;
  logic       up_n, dn_n, mute_n, stby_n;
  logic [5:0] tap_code;
  logic       cmd_stb;
  logic       parked;

  int checks = 0;
  int fails  = 0;
  int ms_count = 0;
  int div = 0;
  int exp_tap[$];
  string exp_req[$];
  int stamps[$];

  always #2 clk = ~clk;

  pb_volume_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .up_n(up_n), .dn_n(dn_n),
    .mute_n(mute_n), .stby_n(stby_n), .tap_code(tap_code), .cmd_stb(cmd_stb),
    .parked(parked)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_tap(input int t, input string req);
    exp_tap.push_back(t);
    exp_req.push_back(req);
  endtask

  task automatic wait_ms(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  task automatic drive(input int which, input logic v);
    case (which)
      0: up_n = v;
      1: dn_n = v;
      default: mute_n = v;
    endcase
  endtask

  task automatic tap_btn(input int which);
    drive(which, 1'b0);
    wait_ms(30);
    drive(which, 1'b1);
    wait_ms(80);
  endtask

  task automatic settle(input string req, input int code);
    wait_ms(20);
    check(exp_tap.size() == 0, req, "strobes still outstanding", exp_tap.size(), 0);
    check(tap_code == 6'(code), req, "held code", int'(tap_code), code);
  endtask

  // millisecond tick, generated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      div     <= 0;
      ms_tick <= 1'b0;
    end else begin
      div     <= (div == 3) ? 0 : div + 1;
      ms_tick <= (div == 3);
      if (div == 3) ms_count <= ms_count + 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cmd_stb === 1'b1) begin
      stamps.push_back(ms_count);
      if (exp_tap.size() == 0) begin
        check(1'b0, "R11", "unexpected strobe, code", int'(tap_code), -1);
      end else begin
        int e;
        string r;
        e = exp_tap.pop_front();
        r = exp_req.pop_front();
        check(tap_code == 6'(e), r, "strobe code", int'(tap_code), e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_n = 1'b1; dn_n = 1'b1; mute_n = 1'b1; stby_n = 1'b1;
    repeat (10) @(negedge clk);
    check(tap_code == 6'd10, "R10", "code in reset", int'(tap_code), 10);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(tap_code == 6'd10, "R10", "code after reset", int'(tap_code), 10);
    check(cmd_stb == 1'b0, "R10", "strobe after reset", int'(cmd_stb), 0);
    check(parked == 1'b0, "R10", "parked after reset", int'(parked), 0);

    // R2 single steps
    expect_tap(9, "R2");  tap_btn(0);
    expect_tap(10, "R2"); tap_btn(1);
    settle("R2", 10);

    // R1 short glitch rejected
    up_n = 1'b0; wait_ms(10); up_n = 1'b1; wait_ms(60);
    settle("R1", 10);

    // R6 re-press inside quiet window
    expect_tap(11, "R6");
    dn_n = 1'b0; wait_ms(22); dn_n = 1'b1; wait_ms(10);
    dn_n = 1'b0; wait_ms(48); dn_n = 1'b1; wait_ms(100);
    settle("R6", 11);
    expect_tap(10, "R2"); tap_btn(0);

    // R5 / R7 mute toggle
    expect_tap(32, "R5"); tap_btn(2);
    tap_btn(1);
    tap_btn(0);
    settle("R7", 32);
    expect_tap(10, "R5"); tap_btn(2);
    settle("R5", 10);

    // R8 simultaneous press
    up_n = 1'b0; dn_n = 1'b0; wait_ms(100);
    up_n = 1'b1; dn_n = 1'b1; wait_ms(80);
    settle("R8", 10);
    expect_tap(9, "R8");
    up_n = 1'b0; wait_ms(100); dn_n = 1'b0; wait_ms(1400);
    up_n = 1'b1; dn_n = 1'b1; wait_ms(80);
    settle("R8", 9);
    expect_tap(10, "R2"); tap_btn(1);

    // R9 standby
    stby_n = 1'b0; wait_ms(10);
    check(parked == 1'b1, "R9", "parked in standby", int'(parked), 1);
    tap_btn(0);
    check(exp_tap.size() == 0 && tap_code == 6'd10, "R9", "code while parked",
          int'(tap_code), 10);
    expect_tap(10, "R9");
    stby_n = 1'b1; wait_ms(10);
    check(parked == 1'b0, "R9", "parked after wake", int'(parked), 0);
    settle("R9", 10);

    // R4 / R3 hold louder down to code 0
    for (int t = 9; t >= 0; t--) expect_tap(t, "R4");
    up_n = 1'b0; wait_ms(3400); up_n = 1'b1; wait_ms(80);
    settle("R3", 0);
    tap_btn(0);
    settle("R3", 0);

    // R4 / R3 hold quieter from 0 to 31 and measure cadence
    stamps.delete();
    for (int t = 1; t <= 31; t++) expect_tap(t, "R4");
    dn_n = 1'b0; wait_ms(6800); dn_n = 1'b1; wait_ms(80);
    settle("R3", 31);
    check(stamps.size() == 31, "R4", "repeat strobe count", stamps.size(), 31);
    if (stamps.size() == 31) begin
      check(stamps[1] - stamps[0] == 1000, "R4", "first repeat gap", stamps[1] - stamps[0], 1000);
      check(stamps[2] - stamps[1] == 250, "R4", "slow gap", stamps[2] - stamps[1], 250);
      check(stamps[17] - stamps[16] == 250, "R4", "last slow gap", stamps[17] - stamps[16], 250);
      check(stamps[18] - stamps[17] == 125, "R4", "first fast gap", stamps[18] - stamps[17], 125);
      check(stamps[30] - stamps[29] == 125, "R4", "late fast gap", stamps[30] - stamps[29], 125);
    end

    // R3 floor, then mute round trip from the floor
    tap_btn(1);
    settle("R3", 31);
    expect_tap(32, "R5"); tap_btn(2);
    expect_tap(31, "R5"); tap_btn(2);
    settle("R5", 31);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule